// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose parallel port of up to 32 pins. Software reaches it through a simple synchronous register bus with address, write enable, write data, read enable and read data. Each pin has its own output-enable bit. A pin configured as an output is driven from an output latch. Every pin's input is brought into the clock domain by a two-flop synchroniser, and software can read the synchronised value at any time.

The port watches its synchronised inputs for transitions and records them per pin in a sticky capture register. Software clears that register by writing ones. A mask register picks which pins may raise the single interrupt line. The trigger kind is fixed when the block is built: rising edge, falling edge, either edge, or high level. In level mode the interrupt follows the live synchronised pin values and does not use the capture register. Software cannot change the trigger kind.

Top module: `pio_port`

## Requirements
- R1: After reset the output latch, output enables, mask and capture registers are all zero, every register reads as zero with the pins held low, and the interrupt is low.
- R2: Address bits [3:2] select the register: 0x0 data, 0x4 direction, 0x8 mask, 0xC capture. Address bits [1:0] are ignored. Read data appears in the cycle after the read-enable cycle and holds until the next read.
- R3: A write to the data offset loads the output latch, which drives `pinOut`. A write to the direction offset sets `pinOutEn`, where a 1 makes the pin an output and a 0 makes it an input.
- R4: A read of the data offset returns the pin inputs after two synchroniser flops, not the output latch. A pin change made just before clock edge k first appears in a read registered at edge k+2.
- R5: Register bits at or above `PIN_COUNT` read as zero, and writes to them have no effect.
- R6: The capture bit of a pin sets when its synchronised input changes in the way the `TRIGGER` parameter selects: 0 to 1 for rising, 1 to 0 for falling, either change for both. In level mode the capture register stays zero.
- R7: A write to the capture offset clears each capture bit where the written word holds a 1. Bits written as 0 keep their value.
- R8: When a new edge and a clearing write reach the same capture bit in the same cycle, the bit ends up set.
- R9: In the edge modes the interrupt is high exactly when some capture bit is set whose mask bit is 1.
- R10: In level mode the interrupt is high exactly when some synchronised pin input is 1 and its mask bit is 1. It follows the pin with the synchroniser delay and drops when the pin falls.
- R11: Capture does not depend on the mask. An edge on a masked-off pin is recorded, and setting its mask bit afterwards raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Byte offset of the register accessed |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| pinIn | input | PIN_COUNT | Asynchronous pin inputs |
| pinOut | output | PIN_COUNT | Output latch values |
| pinOutEn | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds four copies of the block. All four share the same bus and pins. The first has twelve pins and rising-edge capture, so writes and reads of the bits above the pin count can be observed. The other three are full 32-pin ports built for falling-edge, either-edge and level-high triggering. Because all four see the same pin waveform, one stimulus shows how each trigger kind reacts differently. The same-cycle race between an edge and a clearing write is created on the rising-edge copy by timing the write to land on the capture edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int OFFSET_W = 4;
  localparam int BUS_W    = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CAP  = 2'd3
  } sel_e;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrMask;
    logic wrClr;
    logic rdEn;
    sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic [OFFSET_W-1:0] busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  output strobe_t             strobe
);
  sel_e regSel;
  logic unusedAddrLsb;

  assign regSel        = sel_e'(busAddr[3:2]);
  assign unusedAddrLsb = ^busAddr[1:0];

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = busRdEn;
    strobe.rdSel  = regSel;
    if (busWrEn) begin
      unique case (regSel)
        SEL_DATA: strobe.wrOut  = 1'b1;
        SEL_DIR:  strobe.wrDir  = 1'b1;
        SEL_MASK: strobe.wrMask = 1'b1;
        SEL_CAP:  strobe.wrClr  = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    AST_ONE_WRITE_STROBE: assert ($onehot0({strobe.wrOut, strobe.wrDir, strobe.wrMask, strobe.wrClr})); // R2
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT   = 32,
  parameter trig_e TRIGGER     = TRIG_RISE,
  parameter int    SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic [BUS_W-1:0]     rdData,
  output logic                 irq
);
  localparam int N = PIN_COUNT;

  logic [N-1:0] synced, prevSynced, rawEdge;
  logic [N-1:0] outLatch, dirReg, maskReg, capReg, clrBits;
  logic [BUS_W-1:0] rdNext;

  pio_sync #(.WIDTH(N), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (synced)
  );

  if (TRIGGER == TRIG_RISE) begin : gRise
    assign rawEdge = synced & ~prevSynced;
  end else if (TRIGGER == TRIG_FALL) begin : gFall
    assign rawEdge = ~synced & prevSynced;
  end else if (TRIGGER == TRIG_BOTH) begin : gBoth
    assign rawEdge = synced ^ prevSynced;
  end else begin : gLevel
    assign rawEdge = '0;
  end

  assign clrBits = strobe.wrClr ? wrData[N-1:0] : '0;

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      SEL_DATA: rdNext[N-1:0] = synced;
      SEL_DIR:  rdNext[N-1:0] = dirReg;
      SEL_MASK: rdNext[N-1:0] = maskReg;
      SEL_CAP:  rdNext[N-1:0] = capReg;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch   <= '0;
      dirReg     <= '0;
      maskReg    <= '0;
      capReg     <= '0;
      prevSynced <= '0;
      rdData     <= '0;
    end else begin
      if (strobe.wrOut)  outLatch <= wrData[N-1:0];
      if (strobe.wrDir)  dirReg   <= wrData[N-1:0];
      if (strobe.wrMask) maskReg  <= wrData[N-1:0];
      capReg     <= (capReg & ~clrBits) | rawEdge;
      prevSynced <= synced;
      if (strobe.rdEn) rdData <= rdNext;
    end
  end

  if (TRIGGER == TRIG_LEVEL) begin : gIrqLevel
    assign irq = |(synced & maskReg);
    AST_LEVEL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN) capReg == '0); // R6
  end else begin : gIrqEdge
    assign irq = |(capReg & maskReg);
  end

  assign pinOut   = outLatch;
  assign pinOutEn = dirReg;

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rawEdge != '0 |=> (capReg & $past(rawEdge)) == $past(rawEdge)); // R8
  AST_CLEAR_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr |=> (capReg & $past(capReg & ~wrData[N-1:0])) == $past(capReg & ~wrData[N-1:0])); // R7
  AST_NO_SPURIOUS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (capReg & ~$past(capReg) & ~$past(rawEdge)) == '0); // R6
  AST_DIR_SETS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> pinOutEn == $past(wrData[N-1:0])); // R3
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> maskReg != '0); // R9
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData)); // R2
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT   = 32,
  parameter trig_e TRIGGER     = TRIG_RISE,
  parameter int    SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFFSET_W-1:0]  busAddr,
  input  logic                 busWrEn,
  input  logic [BUS_W-1:0]     busWrData,
  input  logic                 busRdEn,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irq
);
  strobe_t strobe;

  pio_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  pio_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .TRIGGER     (TRIGGER),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .rdData   (busRdData),
    .irq      (irq)
  );
endmodule

// File: tb/tb_pio_port.sv
module tb_pio_port;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] pins = '0;

  logic [31:0] rdR, rdF, rdB, rdL;
  logic [11:0] outR, oenR;
  logic [31:0] outF, oenF, outB, oenB, outL, oenL;
  logic        irqR, irqF, irqB, irqL;
  logic [31:0] gotR, gotF, gotB, gotL;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pio_port #(.PIN_COUNT(12), .TRIGGER(TRIG_RISE)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(rdR), .pinIn(pins[11:0]), .pinOut(outR), .pinOutEn(oenR), .irq(irqR));
  pio_port #(.PIN_COUNT(32), .TRIGGER(TRIG_FALL)) dutFall (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(rdF), .pinIn(pins), .pinOut(outF), .pinOutEn(oenF), .irq(irqF));
  pio_port #(.PIN_COUNT(32), .TRIGGER(TRIG_BOTH)) dutBoth (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(rdB), .pinIn(pins), .pinOut(outB), .pinOutEn(oenB), .irq(irqB));
  pio_port #(.PIN_COUNT(32), .TRIGGER(TRIG_LEVEL)) dutLvl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(rdL), .pinIn(pins), .pinOut(outL), .pinOutEn(oenL), .irq(irqL));

  task automatic checkEq(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, actual, expected);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a);
    busAddr = a; busRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
    gotR = rdR; gotF = rdF; gotB = rdB; gotL = rdL;
  endtask

  task automatic clearAll();
    busWrite(4'hC, 32'hFFFF_FFFF);
  endtask

  task automatic testReset();
    for (int a = 0; a < 16; a += 4) begin
      busRead(a[3:0]);
      checkEq("R1 reset read rise", gotR, 32'h0);
      checkEq("R1 reset read fall", gotF, 32'h0);
      checkEq("R1 reset read level", gotL, 32'h0);
    end
    checkEq("R1 reset pinOut", {20'h0, outR}, 32'h0);
    checkEq("R1 reset pinOutEn", {20'h0, oenR}, 32'h0);
    checkEq("R1 reset irq", {28'h0, irqR, irqF, irqB, irqL}, 32'h0);
  endtask

  task automatic testOutputs();
    busWrite(4'h4, 32'hFFFF_FFFF);
    busWrite(4'h0, 32'hA5A5_5A5A);
    checkEq("R3 pinOutEn", {20'h0, oenR}, 32'h0000_0FFF);
    checkEq("R3 pinOut", {20'h0, outR}, 32'h0000_0A5A);
    checkEq("R3 pinOut wide", outL, 32'hA5A5_5A5A);
    busRead(4'h4);
    checkEq("R5 dir upper bits read zero", gotR, 32'h0000_0FFF);
    checkEq("R2 dir read full width", gotL, 32'hFFFF_FFFF);
    busRead(4'h0);
    checkEq("R4 data read is pin input not latch", gotL, 32'h0);
    busWrite(4'h6, 32'h0000_00F0);
    busRead(4'h5);
    checkEq("R2 low address bits ignored", gotL, 32'h0000_00F0);
    checkEq("R3 direction bit 0 makes input", oenL, 32'h0000_00F0);
    busWrite(4'h4, 32'h0);
  endtask

  task automatic testInputSync();
    pins = 32'h0000_0ABC;
    busRead(4'h0);
    checkEq("R4 read at edge k shows old value", gotL, 32'h0);
    busRead(4'h0);
    checkEq("R4 read at edge k+1 shows old value", gotL, 32'h0);
    busRead(4'h0);
    checkEq("R4 read at edge k+2 shows new value", gotL, 32'h0000_0ABC);
    pins = 32'hFFFF_FFFF;
    waitCyc(3);
    busRead(4'h0);
    checkEq("R5 data upper bits read zero", gotR, 32'h0000_0FFF);
    checkEq("R4 data read all ones", gotL, 32'hFFFF_FFFF);
    pins = 32'h0;
    waitCyc(3);
    clearAll();
    busRead(4'hC);
    checkEq("R7 clear all rise", gotR, 32'h0);
    checkEq("R7 clear all both", gotB, 32'h0);
  endtask

  task automatic testCapture();
    pins = 32'h0000_0008;
    waitCyc(4);
    busRead(4'hC);
    checkEq("R6 rising captured", gotR, 32'h0000_0008);
    checkEq("R6 falling ignores rise", gotF, 32'h0);
    checkEq("R6 both captures rise", gotB, 32'h0000_0008);
    checkEq("R6 level mode capture zero", gotL, 32'h0);
    checkEq("R11 masked capture gives no irq", {31'h0, irqR}, 32'h0);
    busWrite(4'h8, 32'h0000_0008);
    checkEq("R11 unmask raises irq", {31'h0, irqR}, 32'h1);
    checkEq("R9 both irq", {31'h0, irqB}, 32'h1);
    checkEq("R9 falling no irq yet", {31'h0, irqF}, 32'h0);
    checkEq("R10 level irq with pin high", {31'h0, irqL}, 32'h1);
    pins = 32'h0;
    waitCyc(4);
    busRead(4'hC);
    checkEq("R6 falling captured", gotF, 32'h0000_0008);
    checkEq("R6 rising keeps bit on fall", gotR, 32'h0000_0008);
    checkEq("R9 falling irq", {31'h0, irqF}, 32'h1);
    checkEq("R10 level irq drops with pin", {31'h0, irqL}, 32'h0);
  endtask

  task automatic testClear();
    pins = 32'h0000_0021;
    waitCyc(4);
    busRead(4'hC);
    checkEq("R6 two more rises", gotR, 32'h0000_0029);
    busWrite(4'hC, 32'h0000_0021);
    busRead(4'hC);
    checkEq("R7 zeros in word keep bits", gotR, 32'h0000_0008);
    checkEq("R9 irq stays with masked bit set", {31'h0, irqR}, 32'h1);
    busWrite(4'hC, 32'h0000_0008);
    busRead(4'hC);
    checkEq("R7 clear last bit", gotR, 32'h0);
    checkEq("R9 irq drops after clear", {31'h0, irqR}, 32'h0);
  endtask

  task automatic testEdgeWins();
    pins = 32'h0000_0020;
    waitCyc(4);
    clearAll();
    pins = 32'h0000_0021;
    @(negedge clk);
    @(negedge clk);
    busWrite(4'hC, 32'h0000_0001);
    busRead(4'hC);
    checkEq("R8 edge wins over clear", gotR, 32'h0000_0001);
    busWrite(4'hC, 32'h0000_0001);
    busRead(4'hC);
    checkEq("R7 later clear works", gotR, 32'h0);
  endtask

  task automatic testUpper();
    busWrite(4'h8, 32'hFFFF_F000);
    busRead(4'h8);
    checkEq("R5 mask upper write ignored", gotR, 32'h0);
    checkEq("R2 mask full width", gotL, 32'hFFFF_F000);
    busWrite(4'h4, 32'hFFFF_F000);
    checkEq("R5 dir upper write no effect", {20'h0, oenR}, 32'h0);
    busWrite(4'h4, 32'h0);
  endtask

  task automatic testLevel();
    busWrite(4'h8, 32'h0000_0080);
    pins = 32'h0000_00A1;
    @(negedge clk);
    checkEq("R10 level irq after one sync flop", {31'h0, irqL}, 32'h0);
    @(negedge clk);
    checkEq("R10 level irq after two sync flops", {31'h0, irqL}, 32'h1);
    pins = 32'h0000_0021;
    waitCyc(2);
    checkEq("R10 level irq falls", {31'h0, irqL}, 32'h0);
    pins = 32'h0000_0001;
    waitCyc(3);
    checkEq("R10 unmasked pin gives no irq", {31'h0, irqL}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOutputs();
    testInputSync();
    testCapture();
    testClear();
    testEdgeWins();
    testUpper();
    testLevel();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule